// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block collects seventeen interrupt sources and hands the most urgent one to a processor core. Five core or software sources sit on fixed priority levels 0 to 4. Twelve peripheral sources each carry an identifier, and a 4-bit field per identifier chooses the priority level that peripheral raises at run time. A peripheral's bit in the pending and enable registers is therefore the level it has been given, not its identifier. Its vector is also set by that level. Several identifiers may share a level, in which case their requests merge into one pending bit.

A rising edge on a request line sets the pending bit of its level. The pending register is ANDed with a 16-bit mask and gated by a global enable. The lowest-numbered level that survives is presented on `irq_o` with its level number and a vector address. The core clears the presented level with `ack_i`. Software can clear pending bits by writing ones to them through a small register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register (address 1) reads 0, the pending register (address 0) reads 0, the control register (address 2, bit 0 = global enable) reads 0, and `irq_o` is low. Peripheral identifier p defaults to level min(5+p, 15), which makes the priority words read 16'h8765, 16'hCBA9 and 16'hFFED.
- R2: A rising edge on `fixed_req_i[k]` (k = 0..4) sets pending bit k. A request that stays high sets the bit only once, so after the bit is cleared it stays clear until the next rising edge.
- R3: A rising edge on `periph_req_i[p]` sets the pending bit whose index equals p's priority field. The field for identifier p is held in the word at address 4 + p/4, bits [4*(p%4)+3 : 4*(p%4)].
- R4: Identifiers given the same level share one pending bit, and an edge from any of them sets that bit.
- R5: `irq_o` is high only when some pending bit is also set in the mask and the global enable is 1. A masked or disabled bit stays pending and can still be read.
- R6: When `irq_o` is high, `irq_level_o` is the lowest-numbered pending and unmasked level, and `vector_o` equals VEC_BASE (default 16'h0100) + 32 × `irq_level_o`.
- R7: `ack_i` while `irq_o` is high clears the pending bit of `irq_level_o`. A write to address 0 clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R8: A new rising edge on a level in the same cycle as an acknowledge or a write-one-to-clear of that level leaves the bit set.
- R9: `irq_o`, `irq_level_o` and `vector_o` reflect a change to the pending, mask or enable state in the same clock in which that register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fixed_req_i | input | 5 | Core/software request lines, fixed levels 0..4 |
| periph_req_i | input | 12 | Peripheral request lines, indexed by identifier |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` |
| ack_i | input | 1 | Core acknowledge of the presented level |
| irq_o | output | 1 | Interrupt request to the core |
| irq_level_o | output | 4 | Level being presented |
| vector_o | output | 16 | Vector address of the presented level |

## Verification
The bench moves a peripheral to a new level and checks that its edge sets the new bit. A controller that kept a fixed source-to-bit map would set the old one. It holds a request high across a clear to catch designs that latch on level instead of edge, because those re-set the bit at once. It stacks two pending levels and acknowledges them one after the other: a wrong priority encoder presents the higher number first, and a wrong acknowledge clears the wrong bit. It also lands a fresh edge in the same cycle as a clear of that bit, which a clear-wins design would lose.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NUM_LVL = 16;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);
  localparam int unsigned VEC_STEP = 32;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic [2:0] {
    A_PEND = 3'd0,
    A_MASK = 3'd1,
    A_CTRL = 3'd2,
    A_PRI0 = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/prio_irq_map.sv
module prio_irq_map
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_FIXED  = 5,
  parameter int unsigned N_PERIPH = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_FIXED-1:0]        fixed_req_i,
  input  logic [N_PERIPH-1:0]       periph_req_i,
  input  logic [N_PERIPH*LVL_W-1:0] periph_lvl_i,
  output logic [NUM_LVL-1:0]        set_o
);
  logic [N_FIXED-1:0]  fixed_q;
  logic [N_PERIPH-1:0] periph_q;
  logic [N_FIXED-1:0]  fixed_rise;
  logic [N_PERIPH-1:0] periph_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fixed_q  <= '0;
      periph_q <= '0;
    end else begin
      fixed_q  <= fixed_req_i;
      periph_q <= periph_req_i;
    end
  end

  assign fixed_rise  = fixed_req_i & ~fixed_q;
  assign periph_rise = periph_req_i & ~periph_q;

  // fixed sources own levels 0..N_FIXED-1; peripherals OR into their level
  always_comb begin
    set_o = '0;
    for (int k = 0; k < N_FIXED; k++)
      if (fixed_rise[k]) set_o[k] = 1'b1;
    for (int p = 0; p < N_PERIPH; p++)
      if (periph_rise[p]) set_o[periph_lvl_i[p*LVL_W +: LVL_W]] = 1'b1;
  end
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_FIXED  = 5,
  parameter int unsigned N_PERIPH = 12,
  localparam int unsigned FLD_PER_W = NUM_LVL / LVL_W,
  localparam int unsigned N_PWORD   = (N_PERIPH + FLD_PER_W - 1) / FLD_PER_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [2:0]                addr_i,
  input  logic [NUM_LVL-1:0]        wdata_i,
  output logic [NUM_LVL-1:0]        rdata_o,
  input  logic [NUM_LVL-1:0]        set_i,
  input  logic                      ack_i,
  input  lvl_t                      ack_lvl_i,
  output logic [NUM_LVL-1:0]        pend_o,
  output logic [NUM_LVL-1:0]        mask_o,
  output logic                      en_o,
  output logic [N_PERIPH*LVL_W-1:0] periph_lvl_o
);
  function automatic logic [NUM_LVL-1:0] pword_default(int unsigned w);
    logic [NUM_LVL-1:0] r;
    int unsigned lv;
    r = '0;
    for (int f = 0; f < FLD_PER_W; f++) begin
      lv = N_FIXED + w * FLD_PER_W + f;
      if (lv > NUM_LVL - 1) lv = NUM_LVL - 1;
      r[f*LVL_W +: LVL_W] = lvl_t'(lv);
    end
    return r;
  endfunction

  logic [NUM_LVL-1:0] pend_q, mask_q, clr;
  logic               en_q;
  logic [NUM_LVL-1:0] pword_q [N_PWORD];
  logic [N_PWORD*NUM_LVL-1:0] pflat;

  always_comb begin
    clr = '0;
    if (ack_i) clr[ack_lvl_i] = 1'b1;
    if (we_i && addr_i == A_PEND) clr = clr | wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | set_i;  // set wins over clear
      if (we_i && addr_i == A_MASK) mask_q <= wdata_i;
      if (we_i && addr_i == A_CTRL) en_q   <= wdata_i[0];
    end
  end

  for (genvar w = 0; w < N_PWORD; w++) begin : g_pword
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pword_q[w] <= pword_default(w);
      else if (we_i && addr_i == 3'(A_PRI0 + w)) pword_q[w] <= wdata_i;
    end
    assign pflat[w*NUM_LVL +: NUM_LVL] = pword_q[w];
  end

  assign periph_lvl_o = pflat[N_PERIPH*LVL_W-1:0];
  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign en_o   = en_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_PEND: rdata_o = pend_q;
      A_MASK: rdata_o = mask_q;
      A_CTRL: rdata_o = {{(NUM_LVL-1){1'b0}}, en_q};
      default: begin
        for (int w = 0; w < N_PWORD; w++)
          if (addr_i == 3'(A_PRI0 + w)) rdata_o = pword_q[w];
      end
    endcase
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
  import prio_irq_pkg::*;
#(
  parameter logic [15:0] VEC_BASE = 16'h0100
) (
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [NUM_LVL-1:0] mask_i,
  input  logic               en_i,
  output logic               irq_o,
  output lvl_t               lvl_o,
  output logic [15:0]        vector_o
);
  logic [NUM_LVL-1:0] live;
  assign live = pend_i & mask_i;

  // scan downward so the lowest live level is left in lvl_o
  always_comb begin
    lvl_o = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--)
      if (live[i]) lvl_o = lvl_t'(i);
  end

  assign irq_o    = en_i & (|live);
  assign vector_o = VEC_BASE + 16'(lvl_o) * 16'(VEC_STEP);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_FIXED  = 5,
  parameter int unsigned N_PERIPH = 12,
  parameter logic [15:0] VEC_BASE = 16'h0100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_FIXED-1:0]  fixed_req_i,
  input  logic [N_PERIPH-1:0] periph_req_i,
  input  logic                we_i,
  input  logic [2:0]          addr_i,
  input  logic [15:0]         wdata_i,
  output logic [15:0]         rdata_o,
  input  logic                ack_i,
  output logic                irq_o,
  output logic [3:0]          irq_level_o,
  output logic [15:0]         vector_o
);
  logic [NUM_LVL-1:0]        set_lvl, pend_q, mask_q;
  logic                      en_q;
  logic [N_PERIPH*LVL_W-1:0] periph_lvl;
  lvl_t                      pick_lvl;

  prio_irq_map #(.N_FIXED(N_FIXED), .N_PERIPH(N_PERIPH)) u_map (
    .clk_i, .rst_ni, .fixed_req_i, .periph_req_i,
    .periph_lvl_i(periph_lvl), .set_o(set_lvl)
  );

  prio_irq_regs #(.N_FIXED(N_FIXED), .N_PERIPH(N_PERIPH)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .set_i(set_lvl), .ack_i(ack_i & irq_o), .ack_lvl_i(pick_lvl),
    .pend_o(pend_q), .mask_o(mask_q), .en_o(en_q), .periph_lvl_o(periph_lvl)
  );

  prio_irq_pick #(.VEC_BASE(VEC_BASE)) u_pick (
    .pend_i(pend_q), .mask_i(mask_q), .en_i(en_q),
    .irq_o, .lvl_o(pick_lvl), .vector_o
  );

  assign irq_level_o = pick_lvl;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter logic [15:0] VEC_BASE = 16'h0100
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] pend_i,
  input logic [15:0] mask_i,
  input logic        en_i,
  input logic [15:0] set_i,
  input logic        ack_i,
  input logic        irq_i,
  input logic [3:0]  lvl_i,
  input logic [15:0] vector_i
);
  assert_irq_gating_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == (en_i && ((pend_i & mask_i) != 16'd0)));

  assert_lowest_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (pend_i[lvl_i] && mask_i[lvl_i] &&
               ((pend_i & mask_i & ((16'd1 << lvl_i) - 16'd1)) == 16'd0)));

  assert_vector_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (vector_i == VEC_BASE + {7'd0, lvl_i, 5'd0}));

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_i && !set_i[lvl_i]) |=> !pend_i[$past(lvl_i)]);

  assert_set_sticks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != 16'd0) |=> ((pend_i & $past(set_i)) == $past(set_i)));

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & ~$past(pend_i | set_i)) == 16'd0));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.VEC_BASE(VEC_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_q), .mask_i(mask_q),
  .en_i(en_q), .set_i(set_lvl), .ack_i(ack_i), .irq_i(irq_o),
  .lvl_i(irq_level_o), .vector_i(vector_o)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 0, rst_ni = 0;
  logic [4:0]  fixed_req = '0;
  logic [11:0] periph_req = '0;
  logic        we = 0, ack = 0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, vector;
  logic        irq;
  logic [3:0]  lvl;
  int n_chk = 0, n_bad = 0;
  localparam logic [15:0] BASE = 16'h0100;

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .fixed_req_i(fixed_req), .periph_req_i(periph_req),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack),
    .irq_o(irq), .irq_level_o(lvl), .vector_o(vector)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_fixed(int k);
    @(negedge clk); fixed_req[k] = 1;
    @(negedge clk); fixed_req[k] = 0;
  endtask

  task automatic pulse_periph(int p);
    @(negedge clk); periph_req[p] = 1;
    @(negedge clk); periph_req[p] = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 irq", irq, 0);
    rd(0, d); chk("R1 pend", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
    rd(2, d); chk("R1 ctrl", d, 0);
    rd(4, d); chk("R1 pri0", d, 16'h8765);
    rd(5, d); chk("R1 pri1", d, 16'hCBA9);
    rd(6, d); chk("R1 pri2", d, 16'hFFED);
  endtask

  task automatic t_fixed;
    logic [15:0] d;
    @(negedge clk); fixed_req[2] = 1;
    rd(0, d); chk("R2 fixed edge", d, 16'h0004);
    wr(0, 16'h0004);
    rd(0, d); chk("R7 w1c", d, 0);
    @(negedge clk);
    rd(0, d); chk("R2 held level no reset", d, 0);
    fixed_req[2] = 0;
  endtask

  task automatic t_periph;
    logic [15:0] d;
    pulse_periph(3);
    rd(0, d); chk("R3 default level", d, 16'h0100);
    wr(0, 16'hFFFF);
    wr(4, 16'h8761);
    pulse_periph(0);
    rd(0, d); chk("R3 remapped level", d, 16'h0002);
    wr(0, 16'hFFFD);
    rd(0, d); chk("R7 w1c zeros kept", d, 16'h0002);
    wr(0, 16'hFFFF);
  endtask

  task automatic t_share;
    logic [15:0] d;
    pulse_periph(10);
    rd(0, d); chk("R4 id10 level15", d, 16'h8000);
    wr(0, 16'h8000);
    pulse_periph(11);
    rd(0, d); chk("R4 id11 level15", d, 16'h8000);
    wr(0, 16'hFFFF);
  endtask

  task automatic t_mask;
    logic [15:0] d;
    wr(2, 16'h0001);
    pulse_fixed(3);
    #1 chk("R5 masked no irq", irq, 0);
    rd(0, d); chk("R5 masked still pending", d, 16'h0008);
    @(negedge clk); we = 1; addr = 1; wdata = 16'h0008;
    @(posedge clk); #1;
    chk("R9 irq same clock", irq, 1);
    @(negedge clk); we = 0;
    chk("R6 level", lvl, 3);
    chk("R6 vector", vector, BASE + 16'd96);
    wr(2, 16'h0000);
    #1 chk("R5 disabled", irq, 0);
    wr(2, 16'h0001);
  endtask

  task automatic t_priority;
    wr(1, 16'hFFFF);
    pulse_periph(3);
    #1 chk("R6 lowest wins", lvl, 3);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk("R7 ack next level", lvl, 8);
    chk("R6 vector 8", vector, BASE + 16'd256);
    chk("R7 irq still", irq, 1);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk("R7 all acked", irq, 0);
  endtask

  task automatic t_race;
    logic [15:0] d;
    pulse_fixed(1);
    @(negedge clk); fixed_req[1] = 1; we = 1; addr = 0; wdata = 16'h0002;
    @(negedge clk); we = 0; fixed_req[1] = 0;
    rd(0, d); chk("R8 edge beats w1c", d, 16'h0002);
    @(negedge clk); fixed_req[1] = 1; ack = 1;
    @(negedge clk); ack = 0; fixed_req[1] = 0;
    rd(0, d); chk("R8 edge beats ack", d, 16'h0002);
    chk("R8 irq level1", lvl, 1);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_fixed();
    t_periph();
    t_share();
    t_mask();
    t_priority();
    t_race();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule